// File: doc/BRIEF.md
# Ownership-Arbitrated Command Mailbox

This block sits between a host processor and an embedded controller and passes 32-bit message words in both directions. Each word carries an 8-bit command type in bits [31:24] and a 24-bit payload in bits [23:0]. The two sides take turns through a shared owner register. A party claims the mailbox by writing its own code, reads the register back, and counts the mailbox as busy if it reads any other code. The holder hands the mailbox back by writing the "none" code.

The host builds an outbound word and then writes the command register. If that write sets both the interrupt-enable bit and the controller-destination bit, the word is latched for the controller and a one-cycle doorbell pulse is raised. Acknowledge and negative-acknowledge replies (type 128 and 129) skip the ownership rule, because the controller still owns the mailbox while it waits for them. The controller posts toward the host by writing its outbound word and then setting the host-notify bit of the command register, which raises the host interrupt. A status register holds write-one-to-clear event flags and an enable that routes them to the host interrupt. One flag is a hang indication from the controller. The other is a reply timeout that the block measures itself.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the owner reads 0, the status register reads 0, the command register reads 0, and `ctrl_doorbell` and `host_irq` are low.
- R2: The owner codes are 0 for none, 1 for controller and 2 for host. A host write of 2 while the owner is 0 makes the owner read 2 on both ports. A host write of 1 or 3 is ignored.
- R3: When both sides write their claim code to a free owner register in the same cycle, the host wins and the owner reads 2.
- R4: The holder frees the mailbox by writing 0. A write to the owner register from the party that does not hold it is ignored. This covers a claim while the mailbox is held and a release by the non-holder (except the case in R8).
- R5: A host write to the command register (address 3) with bit 31 (interrupt enable) and bit 27 (controller destination) both set, while the host owns the mailbox, latches the host message word (address 1) into `ctrl_msg` and drives `ctrl_doorbell` high for exactly the one following cycle. A command write without both bits raises no doorbell.
- R6: If the host message word has type 128 or 129, the R5 post goes through whatever the owner is. For any other type, a post by a host that does not own the mailbox is ignored: there is no doorbell and `ctrl_msg` keeps its value.
- R7: A controller write of bit 29 to its command address sets the host-notify bit, and `host_irq` follows it. A host write to the command register with bit 29 clear clears the bit. Bits 31, 30, 28 and 27 are stored as the host last wrote them and read back, and all other bits read 0.
- R8: While the host-notify bit is set and the controller's message word (address 2) has type 6, 128 or 129, a host write of 0 to the owner register frees a controller-held mailbox. For any other type the write is ignored.
- R9: A non-reply post by the owning host starts a timer. If the owner is still 2 `TIMEOUT_CYC` cycles after the posting edge, status bit 0 is set. The bit is never set before that point.
- R10: Status (address 4): bit 0 is the timeout flag and bit 1 is the hang flag. A controller write of 1 to bit 1 sets the hang flag. A host write of 1 clears a flag and a write of 0 leaves it unchanged. Bit 3 is a plain enable. `host_irq` is the host-notify bit ORed with (enable AND either flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host register write strobe |
| h_addr | input | 3 | Host register address (0 owner, 1 message, 2 controller word, 3 command, 4 status) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for `h_addr` |
| c_wr | input | 1 | Controller register write strobe |
| c_addr | input | 3 | Controller register address (same numbering) |
| c_wdata | input | 32 | Controller write data |
| c_rdata | output | 32 | Controller read data for `c_addr` |
| ctrl_doorbell | output | 1 | One-cycle pulse when a host post is accepted |
| ctrl_msg | output | 32 | Latched host-to-controller word |
| host_irq | output | 1 | Interrupt toward the host |

## Verification
The bench builds the block with `TIMEOUT_CYC` set to 16 instead of the large default. With that value the reply timer expires within a few dozen cycles, so the bench can check the exact edge where the timeout flag appears and the cycle just before it. A scoreboard queue holds every word the bench expects to see on `ctrl_msg` at a doorbell. A doorbell that was not expected is reported as a failure. This catches both posts that should have been blocked and posts that should have gone through.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned TYPE_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CTRL = 2'd1,
    OWN_HOST = 2'd2
  } owner_e;

  localparam logic [ADDR_W-1:0] A_OWNER = 3'd0;
  localparam logic [ADDR_W-1:0] A_MSG_H = 3'd1;
  localparam logic [ADDR_W-1:0] A_MSG_C = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;

  localparam int unsigned CB_IRQ_EN = 31;
  localparam int unsigned CB_TO_HCD = 30;
  localparam int unsigned CB_NOTE   = 29;
  localparam int unsigned CB_WAKE   = 28;
  localparam int unsigned CB_CTRL   = 27;

  localparam int unsigned SB_TMO  = 0;
  localparam int unsigned SB_HANG = 1;
  localparam int unsigned SB_EN   = 3;

  localparam logic [TYPE_W-1:0] T_BW  = 8'd6;
  localparam logic [TYPE_W-1:0] T_ACK = 8'd128;
  localparam logic [TYPE_W-1:0] T_NAK = 8'd129;

  function automatic logic is_reply(input logic [TYPE_W-1:0] t);
    return (t == T_ACK) || (t == T_NAK);
  endfunction

  function automatic logic no_reply_needed(input logic [TYPE_W-1:0] t);
    return (t == T_BW) || is_reply(t);
  endfunction

endpackage

// File: rtl/mbx_owner_arb.sv
module mbx_owner_arb
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       h_wr,
  input  logic [1:0] h_val,
  input  logic       c_wr,
  input  logic [1:0] c_val,
  input  logic       host_may_free,
  output owner_e     owner
);

  owner_e owner_q, owner_d;
  logic   owner_en;
  logic   h_claim, h_free, c_claim, c_free;

  always_comb begin
    h_claim  = h_wr && (h_val == OWN_HOST) && (owner_q == OWN_NONE);
    h_free   = h_wr && (h_val == OWN_NONE) &&
               ((owner_q == OWN_HOST) || ((owner_q == OWN_CTRL) && host_may_free));
    c_claim  = c_wr && (c_val == OWN_CTRL) && (owner_q == OWN_NONE);
    c_free   = c_wr && (c_val == OWN_NONE) && (owner_q == OWN_CTRL);
    owner_en = h_claim || h_free || c_claim || c_free;
    owner_d  = owner_q;
    if (h_claim)               owner_d = OWN_HOST;
    else if (c_claim)          owner_d = OWN_CTRL;
    else if (h_free || c_free) owner_d = OWN_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        owner_q <= OWN_NONE;
    else if (owner_en) owner_q <= owner_d;
  end

  assign owner = owner_q;

  // R4: ownership never passes straight from one party to the other
  a_r4_no_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != OWN_NONE) |=> ((owner_q == $past(owner_q)) || (owner_q == OWN_NONE)));

  // R2: the unused code never appears
  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    owner_q != 2'b11);

  // R3: simultaneous claim goes to the host
  a_r3_host_first: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && (h_val == OWN_HOST) && c_wr && (c_val == OWN_CTRL) && (owner_q == OWN_NONE))
    |=> (owner_q == OWN_HOST));

endmodule

// File: rtl/mbx_msg_regs.sv
module mbx_msg_regs
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [WORD_W-1:0] h_wdata,
  input  logic              c_wr,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [WORD_W-1:0] c_wdata,
  input  owner_e            owner,
  output logic [WORD_W-1:0] msg_h_q,
  output logic [WORD_W-1:0] msg_c_q,
  output logic [WORD_W-1:0] cmd_q,
  output logic [WORD_W-1:0] inbox_q,
  output logic              doorbell_q,
  output logic              post_start
);

  localparam logic [WORD_W-1:0] CMD_MASK =
    (WORD_W'(1) << CB_IRQ_EN) | (WORD_W'(1) << CB_TO_HCD) | (WORD_W'(1) << CB_NOTE) |
    (WORD_W'(1) << CB_WAKE)   | (WORD_W'(1) << CB_CTRL);

  logic              msg_h_en, msg_c_en, cmd_en, h_cmd_wr, c_note_set;
  logic              post_req, bypass, post_ok;
  logic [WORD_W-1:0] cmd_d;

  always_comb begin
    msg_h_en   = h_wr && (h_addr == A_MSG_H);
    msg_c_en   = c_wr && (c_addr == A_MSG_C);
    h_cmd_wr   = h_wr && (h_addr == A_CMD);
    c_note_set = c_wr && (c_addr == A_CMD) && c_wdata[CB_NOTE];
    cmd_en     = h_cmd_wr || c_note_set;
    post_req   = h_cmd_wr && h_wdata[CB_IRQ_EN] && h_wdata[CB_CTRL];
    bypass     = is_reply(msg_h_q[WORD_W-1 -: TYPE_W]);
    post_ok    = post_req && ((owner == OWN_HOST) || bypass);
    post_start = post_req && (owner == OWN_HOST) && !bypass;
    cmd_d      = cmd_q;
    if (h_cmd_wr) begin
      cmd_d          = h_wdata & CMD_MASK;
      cmd_d[CB_NOTE] = cmd_q[CB_NOTE] & h_wdata[CB_NOTE];
    end
    if (c_note_set) cmd_d[CB_NOTE] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        msg_h_q <= '0;
    else if (msg_h_en) msg_h_q <= h_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        msg_c_q <= '0;
    else if (msg_c_en) msg_c_q <= c_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       inbox_q <= '0;
    else if (post_ok) inbox_q <= msg_h_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) doorbell_q <= 1'b0;
    else        doorbell_q <= post_ok;
  end

  // R5: a doorbell always carries the word that was staged before it
  a_r5_inbox_word: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell_q |-> (inbox_q == $past(msg_h_q)));

  // R6: a doorbell needs host ownership or a reply type
  a_r6_post_gate: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell_q |-> (($past(owner) == OWN_HOST) || is_reply($past(msg_h_q[WORD_W-1 -: TYPE_W]))));

endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_wr,
  input  logic clr_tmo,
  input  logic clr_hang,
  input  logic en_val,
  input  logic hang_set,
  input  logic post_start,
  input  logic owner_is_host,
  output logic tmo_q,
  output logic hang_q,
  output logic en_q
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic             busy_q, busy_d, tmr_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tmo_d, hang_d, en_d, tmo_set, flag_en;

  always_comb begin
    tmo_set = busy_q && owner_is_host && (cnt_q == LAST);
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    if (post_start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q && (!owner_is_host || (cnt_q == LAST))) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end
    tmr_en  = post_start || busy_q;
    tmo_d   = tmo_set  || (tmo_q  && !(clr_wr && clr_tmo));
    hang_d  = hang_set || (hang_q && !(clr_wr && clr_hang));
    en_d    = clr_wr ? en_val : en_q;
    flag_en = clr_wr || hang_set || tmo_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tmr_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= 1'b0;
      hang_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (flag_en) begin
      tmo_q  <= tmo_d;
      hang_q <= hang_d;
      en_q   <= en_d;
    end
  end

  // R9: the timeout flag only appears while the host still holds the mailbox
  a_r9_tmo_host: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(owner_is_host));

  // R10: a host one clears the hang flag unless the controller sets it again
  a_r10_hang_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_hang && !hang_set) |=> !hang_q);

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_wr,
  input  logic [2:0]  h_addr,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  input  logic        c_wr,
  input  logic [2:0]  c_addr,
  input  logic [31:0] c_wdata,
  output logic [31:0] c_rdata,
  output logic        ctrl_doorbell,
  output logic [31:0] ctrl_msg,
  output logic        host_irq
);

  logic [1:0]        rs_q;
  logic              rst_sync_n;
  owner_e            owner;
  logic [WORD_W-1:0] msg_h_q, msg_c_q, cmd_q, inbox_q, stat_word, owner_word;
  logic              post_start, host_may_free;
  logic              tmo_q, hang_q, en_q;
  logic              h_own_wr, c_own_wr, h_stat_wr, c_hang_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  always_comb begin
    h_own_wr      = h_wr && (h_addr == A_OWNER);
    c_own_wr      = c_wr && (c_addr == A_OWNER);
    h_stat_wr     = h_wr && (h_addr == A_STAT);
    c_hang_set    = c_wr && (c_addr == A_STAT) && c_wdata[SB_HANG];
    host_may_free = cmd_q[CB_NOTE] && no_reply_needed(msg_c_q[WORD_W-1 -: TYPE_W]);
  end

  mbx_owner_arb u_arb (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .h_wr          (h_own_wr),
    .h_val         (h_wdata[1:0]),
    .c_wr          (c_own_wr),
    .c_val         (c_wdata[1:0]),
    .host_may_free (host_may_free),
    .owner         (owner)
  );

  mbx_msg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .h_wr       (h_wr),
    .h_addr     (h_addr),
    .h_wdata    (h_wdata),
    .c_wr       (c_wr),
    .c_addr     (c_addr),
    .c_wdata    (c_wdata),
    .owner      (owner),
    .msg_h_q    (msg_h_q),
    .msg_c_q    (msg_c_q),
    .cmd_q      (cmd_q),
    .inbox_q    (inbox_q),
    .doorbell_q (ctrl_doorbell),
    .post_start (post_start)
  );

  mbx_status #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_stat (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .clr_wr        (h_stat_wr),
    .clr_tmo       (h_wdata[SB_TMO]),
    .clr_hang      (h_wdata[SB_HANG]),
    .en_val        (h_wdata[SB_EN]),
    .hang_set      (c_hang_set),
    .post_start    (post_start),
    .owner_is_host (owner == OWN_HOST),
    .tmo_q         (tmo_q),
    .hang_q        (hang_q),
    .en_q          (en_q)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[SB_TMO]  = tmo_q;
    stat_word[SB_HANG] = hang_q;
    stat_word[SB_EN]   = en_q;
    owner_word         = {{(WORD_W-2){1'b0}}, owner};
    unique case (h_addr)
      A_OWNER: h_rdata = owner_word;
      A_MSG_H: h_rdata = msg_h_q;
      A_MSG_C: h_rdata = msg_c_q;
      A_CMD:   h_rdata = cmd_q;
      A_STAT:  h_rdata = stat_word;
      default: h_rdata = '0;
    endcase
    unique case (c_addr)
      A_OWNER: c_rdata = owner_word;
      A_MSG_H: c_rdata = inbox_q;
      A_MSG_C: c_rdata = msg_c_q;
      A_CMD:   c_rdata = cmd_q;
      A_STAT:  c_rdata = stat_word;
      default: c_rdata = '0;
    endcase
  end

  assign ctrl_msg = inbox_q;
  assign host_irq = cmd_q[CB_NOTE] || (en_q && (tmo_q || hang_q));

  // R7: the interrupt never rises without a notify or an enabled flag
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(host_irq) |-> (cmd_q[CB_NOTE] || en_q));

endmodule

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;

  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr = 1'b0, c_wr = 1'b0;
  logic [2:0]  h_addr = '0, c_addr = '0;
  logic [31:0] h_wdata = '0, c_wdata = '0;
  logic [31:0] h_rdata, c_rdata, ctrl_msg;
  logic        ctrl_doorbell, host_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit running  = 1'b0;
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;

  cmd_mailbox #(.TIMEOUT_CYC(TMO)) u_cmd_mailbox (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .c_wr(c_wr), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .ctrl_doorbell(ctrl_doorbell), .ctrl_msg(ctrl_msg), .host_irq(host_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic cwr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); c_wr = 1'b1; c_addr = a; c_wdata = d;
    @(negedge clk); c_wr = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); h_addr = a; #1 d = h_rdata;
  endtask

  task automatic crd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); c_addr = a; #1 d = c_rdata;
  endtask

  // stage a word and ring the controller; expect_bell pushes to the scoreboard
  task automatic post(input logic [31:0] w, input bit expect_bell);
    hwr(3'd1, w);
    if (expect_bell) exp_q.push_back(w);
    hwr(3'd3, 32'h8800_0000);
  endtask

  // monitor: every doorbell must match the next expected word
  initial begin
    forever begin
      @(negedge clk);
      if (running && ctrl_doorbell) begin
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R6: actual unexpected doorbell word %h expected no doorbell", ctrl_msg);
        end else begin
          check("R5 doorbell word", ctrl_msg, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1'b1;

    // R1 reset state
    hrd(3'd0, v); check("R1 owner", v, 0);
    hrd(3'd4, v); check("R1 status", v, 0);
    hrd(3'd3, v); check("R1 cmd", v, 0);
    check("R1 doorbell", {31'b0, ctrl_doorbell}, 0);
    check("R1 irq", {31'b0, host_irq}, 0);

    // R2 host claim and illegal codes
    hwr(3'd0, 32'd2);
    hrd(3'd0, v); check("R2 host claim", v, 2);
    crd(3'd0, v); check("R2 ctrl view", v, 2);
    hwr(3'd0, 32'd1);
    hrd(3'd0, v); check("R2 host writes ctrl code", v, 2);
    hwr(3'd0, 32'd3);
    hrd(3'd0, v); check("R2 code 3 ignored", v, 2);

    // R5 post while owning, single-cycle doorbell
    post(32'h0512_3456, 1'b1);
    @(negedge clk); check("R5 one cycle", {31'b0, ctrl_doorbell}, 0);
    // R4 non-holder writes ignored
    cwr(3'd0, 32'd1);
    hrd(3'd0, v); check("R4 ctrl claim while held", v, 2);
    cwr(3'd0, 32'd0);
    hrd(3'd0, v); check("R4 ctrl free while host holds", v, 2);
    // R5 cmd without both bits: no doorbell
    hwr(3'd3, 32'h8000_0000);
    check("R5 no bell without dest", {31'b0, ctrl_doorbell}, 0);
    hwr(3'd0, 32'd0);
    hrd(3'd0, v); check("R4 holder release", v, 0);

    // R3 simultaneous claim
    @(negedge clk);
    h_wr = 1'b1; h_addr = 3'd0; h_wdata = 32'd2;
    c_wr = 1'b1; c_addr = 3'd0; c_wdata = 32'd1;
    @(negedge clk); h_wr = 1'b0; c_wr = 1'b0;
    hrd(3'd0, v); check("R3 host wins", v, 2);
    hwr(3'd0, 32'd0);

    // R7/R8 controller message needing a reply
    cwr(3'd0, 32'd1);
    crd(3'd0, v); check("R2 ctrl claim", v, 1);
    cwr(3'd2, 32'h07AB_CDEF);
    cwr(3'd3, 32'h2000_0000);
    check("R7 irq on notify", {31'b0, host_irq}, 1);
    hrd(3'd2, v); check("R7 ctrl word", v, 32'h07AB_CDEF);
    hwr(3'd0, 32'd0);
    hrd(3'd0, v); check("R8 free ignored for type 7", v, 1);
    hwr(3'd3, 32'h0000_0000);
    check("R7 irq cleared", {31'b0, host_irq}, 0);
    // R6 ack bypasses ownership
    post(32'h80AB_CDEF, 1'b1);
    cwr(3'd0, 32'd0);
    hrd(3'd0, v); check("R4 ctrl release", v, 0);
    // R6 non-reply post without ownership is dropped
    post(32'h0900_0001, 1'b0);
    @(negedge clk);
    check("R6 ctrl_msg kept", ctrl_msg, 32'h80AB_CDEF);

    // R8 bandwidth-type message lets host free
    cwr(3'd0, 32'd1);
    cwr(3'd2, 32'h0600_0010);
    cwr(3'd3, 32'h2000_0000);
    hwr(3'd0, 32'd0);
    hrd(3'd0, v); check("R8 host frees for type 6", v, 0);

    // R7 command readback
    hwr(3'd3, 32'h5000_0000);
    hrd(3'd3, v); check("R7 cmd readback", v, 32'h5000_0000);
    check("R7 irq off", {31'b0, host_irq}, 0);

    // R9 reply timeout
    hwr(3'd0, 32'd2);
    post(32'h0500_0002, 1'b1);
    repeat (TMO - 2) @(negedge clk);
    hrd(3'd4, v); check("R9 not yet", v, 0);
    hrd(3'd4, v); check("R9 expired", v, 1);
    check("R10 irq gated by enable", {31'b0, host_irq}, 0);
    hwr(3'd0, 32'd0);

    // R10 status enable and write-one-to-clear
    hwr(3'd4, 32'h8);
    check("R10 irq enabled", {31'b0, host_irq}, 1);
    hwr(3'd4, 32'h9);
    hrd(3'd4, v); check("R10 clear timeout", v, 32'h8);
    check("R10 irq low", {31'b0, host_irq}, 0);
    cwr(3'd4, 32'h2);
    hrd(3'd4, v); check("R10 hang set", v, 32'hA);
    check("R10 irq on hang", {31'b0, host_irq}, 1);
    hwr(3'd4, 32'h8);
    hrd(3'd4, v); check("R10 zero leaves hang", v, 32'hA);
    hwr(3'd4, 32'hA);
    hrd(3'd4, v); check("R10 hang cleared", v, 32'h8);

    repeat (2) @(negedge clk);
    check("R5 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule